// File: doc/BRIEF.md
# Sector ECC Correction Applier

This block repairs one 512-byte sector that already sits in an on-chip byte RAM, using the output of a 4-symbol error decoder. The sector is protected by 10 check bytes, and the decoder can correct up to four bad symbols. It reports its findings as four 32-bit result words. Each word names a byte position and an 8-bit XOR pattern. For every word that carries a real correction, the applier reads the byte at that position, XORs in the pattern and writes the result back. A sticky flag records that the sector could not be fully repaired.

The result words arrive as one bundle. `dec_end` is the valid signal for the bundle, and `res_ready` is the matching ready. A bundle is taken only in a cycle where both are high. `res_ready` is high only while the block is idle and no sector restart is requested in that cycle. The decoder must hold `dec_end`, `res_words` and `dec_fail` steady until the bundle is taken. While the block is busy it ignores the bundle inputs completely, which is how back-pressure works here.

A slot that has already been handled is not handled again for the same sector, so repeated end events cause no further writes. `sector_start` opens a new sector. The block signals the end of each pass with a one-cycle done pulse, and in the same cycle it pulses `stat_clr` so that the decoder can clear its status.

Top module: `ecc_sector_fixer`

## Requirements
- R1: After reset `res_ready` is 1, and `fix_done`, `stat_clr`, `uncorrectable`, `ram_re` and `ram_we` are all 0.
- R2: A bundle is taken only when `dec_end` and `res_ready` are both high. `res_ready` is low in every cycle where the block is busy or `sector_start` is high. A `dec_end` raised while the block is busy causes no RAM access and no second done pulse.
- R3: Each result word carries the byte index in bits 31:16 and the XOR mask in bits 7:0. The byte at that index is replaced by its old value XOR the mask.
- R4: A correction takes two cycles. In the first, `ram_re` is high with the address. In the next, `ram_we` is high with the same address, and the RAM read data is assumed to arrive one cycle after `ram_re`. A slot that is skipped takes one cycle. Slots are examined in order from 0 to 3.
- R5: A word equal to 0x03FF03FF is empty. It causes no RAM access and does not raise `uncorrectable`.
- R6: Once a slot has been applied or flagged in a sector, that slot is skipped in every later bundle until `sector_start`.
- R7: If `dec_fail` is high when a bundle is taken, `uncorrectable` is set, no RAM access follows, and `fix_done` pulses in the very next cycle.
- R8: An index of 512 or more causes no RAM access and sets `uncorrectable`.
- R9: Once all four slots have been examined, `fix_done` and `stat_clr` are high for exactly one cycle. With no failure, this happens 1 + (sum of slot costs) cycles after the bundle is taken.
- R10: `uncorrectable` stays set until `sector_start` is seen while the block is idle. That also clears every slot mark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sector_start | input | 1 | Begins a new sector: clears the flag and the slot marks (taken when idle) |
| dec_end | input | 1 | Decode-end strobe; serves as valid for the result bundle |
| res_ready | output | 1 | Bundle can be taken this cycle |
| dec_fail | input | 1 | The decoder could not correct the sector |
| res_words | input | 128 | Four result words; slot n occupies bits 32n+31:32n |
| ram_re | output | 1 | Sector RAM read strobe |
| ram_we | output | 1 | Sector RAM write strobe |
| ram_addr | output | 9 | Sector RAM byte address |
| ram_wdata | output | 8 | Corrected byte |
| ram_rdata | input | 8 | RAM read data, valid the cycle after `ram_re` |
| fix_done | output | 1 | One-cycle pulse when the pass is over |
| stat_clr | output | 1 | One-cycle pulse telling the decoder to clear its status |
| uncorrectable | output | 1 | Sticky per-sector failure flag |

## Verification
The bound checker watches the properties that must hold on every cycle:

- every write comes one cycle after a read to the same address;
- every read is followed by a write;
- the done pulse lasts a single cycle;
- the idle state makes no RAM access;
- a failed decode goes straight to done without touching the RAM;
- the flag stays set until a restart.

Some behaviours need whole scenarios, and only the bench's reference model shows them. These are the actual byte values after the XOR, the order of the slots, the skipping of empty and already-handled slots across repeated bundles, the handling of out-of-range indices, and the exact number of cycles before done for each mix of slots.

// File: rtl/ecc_fix_pkg.sv
package ecc_fix_pkg;
  localparam int unsigned FIX_SLOTS      = 4;
  localparam int unsigned FIX_SECT_BYTES = 512;
  localparam int unsigned FIX_WORD_W     = 32;
  localparam int unsigned FIX_IDX_W      = 16;
  localparam int unsigned FIX_MASK_W     = 8;
  localparam logic [31:0] FIX_EMPTY_WORD = 32'h03FF03FF;

  typedef enum logic [1:0] {
    FX_IDLE = 2'd0,
    FX_SCAN = 2'd1,
    FX_MOD  = 2'd2,
    FX_FIN  = 2'd3
  } fix_state_e;
endpackage

// File: rtl/ecc_slot_decode.sv
module ecc_slot_decode #(
  parameter int unsigned WORD_W     = 32,
  parameter int unsigned IDX_W      = 16,
  parameter int unsigned MASK_W     = 8,
  parameter int unsigned SECT_BYTES = 512,
  parameter int unsigned ADDR_W     = 9,
  parameter logic [WORD_W-1:0] EMPTY = 32'h03FF03FF
) (
  input  logic [WORD_W-1:0] word,
  output logic              empty,
  output logic              in_range,
  output logic [ADDR_W-1:0] byte_addr,
  output logic [MASK_W-1:0] mask
);
  logic [IDX_W-1:0] idx;

  // index in the top field, pattern in the bottom field
  assign idx       = word[WORD_W-1 -: IDX_W];
  assign empty     = (word == EMPTY);
  assign in_range  = (idx < IDX_W'(SECT_BYTES));
  assign byte_addr = idx[ADDR_W-1:0];
  assign mask      = word[MASK_W-1:0];
endmodule

// File: rtl/ecc_slot_bank.sv
module ecc_slot_bank #(
  parameter int unsigned NSLOT      = 4,
  parameter int unsigned WORD_W     = 32,
  parameter int unsigned IDX_W      = 16,
  parameter int unsigned MASK_W     = 8,
  parameter int unsigned SECT_BYTES = 512,
  parameter int unsigned ADDR_W     = 9,
  parameter int unsigned SLOT_W     = 2,
  parameter logic [WORD_W-1:0] EMPTY = 32'h03FF03FF
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic [NSLOT*WORD_W-1:0] words,
  input  logic [SLOT_W-1:0]       sel,
  input  logic                    mark_set,
  input  logic                    mark_clr,
  output logic                    cur_empty,
  output logic                    cur_marked,
  output logic                    cur_in_range,
  output logic [ADDR_W-1:0]       cur_addr,
  output logic [MASK_W-1:0]       cur_mask
);
  logic [WORD_W-1:0] word_q [NSLOT];
  logic [NSLOT-1:0]  mark_q;
  logic [NSLOT-1:0]  emp_a;
  logic [NSLOT-1:0]  inr_a;
  logic [ADDR_W-1:0] addr_a [NSLOT];
  logic [MASK_W-1:0] mask_a [NSLOT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSLOT; i++) word_q[i] <= EMPTY;
    end else if (load) begin
      for (int i = 0; i < NSLOT; i++) word_q[i] <= words[i*WORD_W +: WORD_W];
    end
  end

  // per-slot "already handled" marks for the current sector
  always_ff @(posedge clk) begin
    if (!rst_n)        mark_q <= '0;
    else if (mark_clr) mark_q <= '0;
    else if (mark_set) mark_q[sel] <= 1'b1;
  end

  for (genvar g = 0; g < NSLOT; g++) begin : g_dec
    ecc_slot_decode #(
      .WORD_W(WORD_W), .IDX_W(IDX_W), .MASK_W(MASK_W),
      .SECT_BYTES(SECT_BYTES), .ADDR_W(ADDR_W), .EMPTY(EMPTY)
    ) u_dec (
      .word      (word_q[g]),
      .empty     (emp_a[g]),
      .in_range  (inr_a[g]),
      .byte_addr (addr_a[g]),
      .mask      (mask_a[g])
    );
  end

  assign cur_empty    = emp_a[sel];
  assign cur_marked   = mark_q[sel];
  assign cur_in_range = inr_a[sel];
  assign cur_addr     = addr_a[sel];
  assign cur_mask     = mask_a[sel];
endmodule

// File: rtl/ecc_rmw_seq.sv
module ecc_rmw_seq
  import ecc_fix_pkg::*;
#(
  parameter int unsigned NSLOT  = 4,
  parameter int unsigned ADDR_W = 9,
  parameter int unsigned MASK_W = 8,
  parameter int unsigned SLOT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sector_start,
  input  logic              dec_end,
  input  logic              dec_fail,
  output logic              res_ready,
  output logic              load,
  output logic [SLOT_W-1:0] sel,
  output logic              mark_set,
  output logic              mark_clr,
  input  logic              cur_empty,
  input  logic              cur_marked,
  input  logic              cur_in_range,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [MASK_W-1:0] cur_mask,
  output logic              ram_re,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [MASK_W-1:0] ram_wdata,
  input  logic [MASK_W-1:0] ram_rdata,
  output logic              fix_done,
  output logic              stat_clr,
  output logic              uncorrectable
);
  fix_state_e        state_q, state_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic              unc_q, unc_d;
  logic              accept, skip, last, bad_idx;

  assign res_ready = (state_q == FX_IDLE) && !sector_start;
  assign accept    = res_ready && dec_end;
  assign load      = accept;
  assign mark_clr  = (state_q == FX_IDLE) && sector_start;
  assign sel       = slot_q;

  assign skip    = cur_empty || cur_marked;
  assign bad_idx = (state_q == FX_SCAN) && !skip && !cur_in_range;
  assign last    = (slot_q == SLOT_W'(NSLOT - 1));

  assign ram_re    = (state_q == FX_SCAN) && !skip && cur_in_range;
  assign ram_we    = (state_q == FX_MOD);
  assign ram_addr  = (ram_re || ram_we) ? cur_addr : '0;
  assign ram_wdata = ram_we ? (ram_rdata ^ cur_mask) : '0;
  assign mark_set  = ram_we || bad_idx;

  assign fix_done      = (state_q == FX_FIN);
  assign stat_clr      = (state_q == FX_FIN);
  assign uncorrectable = unc_q;

  always_comb begin
    state_d = state_q;
    slot_d  = slot_q;
    unc_d   = unc_q;
    unique case (state_q)
      FX_IDLE: begin
        if (mark_clr) begin
          unc_d = 1'b0;
        end else if (accept) begin
          slot_d = '0;
          if (dec_fail) begin
            unc_d   = 1'b1;
            state_d = FX_FIN;
          end else begin
            state_d = FX_SCAN;
          end
        end
      end
      FX_SCAN: begin
        if (ram_re) begin
          state_d = FX_MOD;
        end else begin
          if (bad_idx) unc_d = 1'b1;
          state_d = last ? FX_FIN : FX_SCAN;
          slot_d  = last ? slot_q : slot_q + 1'b1;
        end
      end
      FX_MOD: begin
        state_d = last ? FX_FIN : FX_SCAN;
        slot_d  = last ? slot_q : slot_q + 1'b1;
      end
      FX_FIN: state_d = FX_IDLE;
      default: state_d = FX_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= FX_IDLE;
      slot_q  <= '0;
      unc_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      slot_q  <= slot_d;
      unc_q   <= unc_d;
    end
  end
endmodule

// File: rtl/ecc_sector_fixer.sv
module ecc_sector_fixer
  import ecc_fix_pkg::*;
#(
  parameter int unsigned NSLOT      = FIX_SLOTS,
  parameter int unsigned SECT_BYTES = FIX_SECT_BYTES,
  parameter int unsigned WORD_W     = FIX_WORD_W,
  parameter int unsigned IDX_W      = FIX_IDX_W,
  parameter int unsigned MASK_W     = FIX_MASK_W,
  localparam int unsigned ADDR_W    = $clog2(SECT_BYTES),
  localparam int unsigned SLOT_W    = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sector_start,
  input  logic                    dec_end,
  output logic                    res_ready,
  input  logic                    dec_fail,
  input  logic [NSLOT*WORD_W-1:0] res_words,
  output logic                    ram_re,
  output logic                    ram_we,
  output logic [ADDR_W-1:0]       ram_addr,
  output logic [MASK_W-1:0]       ram_wdata,
  input  logic [MASK_W-1:0]       ram_rdata,
  output logic                    fix_done,
  output logic                    stat_clr,
  output logic                    uncorrectable
);
  logic              load, mark_set, mark_clr;
  logic [SLOT_W-1:0] sel;
  logic              cur_empty, cur_marked, cur_in_range;
  logic [ADDR_W-1:0] cur_addr;
  logic [MASK_W-1:0] cur_mask;

  ecc_slot_bank #(
    .NSLOT(NSLOT), .WORD_W(WORD_W), .IDX_W(IDX_W), .MASK_W(MASK_W),
    .SECT_BYTES(SECT_BYTES), .ADDR_W(ADDR_W), .SLOT_W(SLOT_W),
    .EMPTY(WORD_W'(FIX_EMPTY_WORD))
  ) u_bank (
    .clk, .rst_n, .load, .words(res_words), .sel, .mark_set, .mark_clr,
    .cur_empty, .cur_marked, .cur_in_range, .cur_addr, .cur_mask
  );

  ecc_rmw_seq #(
    .NSLOT(NSLOT), .ADDR_W(ADDR_W), .MASK_W(MASK_W), .SLOT_W(SLOT_W)
  ) u_seq (
    .clk, .rst_n, .sector_start, .dec_end, .dec_fail, .res_ready, .load,
    .sel, .mark_set, .mark_clr, .cur_empty, .cur_marked, .cur_in_range,
    .cur_addr, .cur_mask, .ram_re, .ram_we, .ram_addr, .ram_wdata,
    .ram_rdata, .fix_done, .stat_clr, .uncorrectable
  );
endmodule

// File: rtl/ecc_sector_fixer_chk.sv
module ecc_sector_fixer_chk #(
  parameter int unsigned ADDR_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sector_start,
  input logic              dec_end,
  input logic              dec_fail,
  input logic              res_ready,
  input logic              ram_re,
  input logic              ram_we,
  input logic [ADDR_W-1:0] ram_addr,
  input logic              fix_done,
  input logic              uncorrectable
);
  AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> ($past(ram_re) && ram_addr == $past(ram_addr))); // R4
  AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ram_re |=> ram_we); // R4
  AST_FAIL_SKIPS_RAM: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_end && res_ready && dec_fail) |=> (fix_done && !ram_re && !ram_we)); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    fix_done |=> !fix_done); // R9
  AST_IDLE_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    res_ready |-> (!ram_re && !ram_we && !fix_done)); // R2
  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (uncorrectable && !sector_start) |=> uncorrectable); // R10
endmodule

bind ecc_sector_fixer ecc_sector_fixer_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk, .rst_n, .sector_start, .dec_end, .dec_fail, .res_ready,
  .ram_re, .ram_we, .ram_addr, .fix_done, .uncorrectable
);

// File: tb/ecc_sector_fixer_bench.sv
`timescale 1ns/1ps
module ecc_sector_fixer_bench;
  localparam logic [31:0] NOERR = 32'h03FF03FF;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         sector_start = 1'b0, dec_end = 1'b0, dec_fail = 1'b0;
  logic [127:0] res_words = {4{NOERR}};
  logic         res_ready, ram_re, ram_we, fix_done, stat_clr, uncorrectable;
  logic [8:0]   ram_addr;
  logic [7:0]   ram_wdata, ram_rdata;

  always #2.5 clk = ~clk;

  ecc_sector_fixer u_ecc_sector_fixer (
    .clk, .rst_n, .sector_start, .dec_end, .res_ready, .dec_fail, .res_words,
    .ram_re, .ram_we, .ram_addr, .ram_wdata, .ram_rdata, .fix_done,
    .stat_clr, .uncorrectable
  );

  int checks = 0, errors = 0, cycles = 0, writes = 0;
  bit finished = 0;
  logic [7:0] mem [512];
  logic [7:0] ref_mem [512];
  int wr_q[$];

  function automatic logic [7:0] seed(int i);
    return 8'((i * 7 + 3) & 8'hFF);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // sector RAM with one-cycle read latency
  always @(posedge clk) begin
    if (ram_we) mem[ram_addr] <= ram_wdata;
    if (ram_re) ram_rdata <= mem[ram_addr];
  end

  // behavioural reference: 0 idle, 1 scan, 2 modify, 3 finish
  int m_state = 0, m_slot = 0;
  bit m_unc = 0;
  bit m_mark [4];
  logic [31:0] m_w [4];

  function automatic bit m_live(int s);
    return m_w[s] != NOERR && !m_mark[s];
  endfunction

  task automatic m_adv();
    if (m_slot == 3) m_state = 3; else begin m_slot++; m_state = 1; end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = 0; m_slot = 0; m_unc = 0;
      foreach (m_mark[i]) m_mark[i] = 0;
    end else begin
      case (m_state)
        0: if (sector_start) begin
             m_unc = 0; foreach (m_mark[i]) m_mark[i] = 0;
           end else if (dec_end) begin
             for (int s = 0; s < 4; s++) m_w[s] = res_words[s*32 +: 32];
             m_slot = 0;
             if (dec_fail) begin m_unc = 1; m_state = 3; end else m_state = 1;
           end
        1: if (!m_live(m_slot)) m_adv();
           else if (m_w[m_slot][31:16] >= 512) begin
             m_unc = 1; m_mark[m_slot] = 1; m_adv();
           end else m_state = 2;
        2: begin
             ref_mem[m_w[m_slot][24:16]] ^= m_w[m_slot][7:0];
             m_mark[m_slot] = 1; m_adv();
           end
        default: m_state = 0;
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      bit exp_re;
      exp_re = (m_state == 1) && m_live(m_slot) && (m_w[m_slot][31:16] < 512);
      chk(res_ready == (m_state == 0 && !sector_start), "R2 ready", int'(res_ready), 0);
      chk(fix_done == (m_state == 3), "R9 done", int'(fix_done), m_state);
      chk(stat_clr == (m_state == 3), "R9 stat_clr", int'(stat_clr), m_state);
      chk(ram_re == exp_re, "R4 R5 R8 read", int'(ram_re), int'(exp_re));
      chk(ram_we == (m_state == 2), "R4 write", int'(ram_we), m_state);
      chk(uncorrectable == m_unc, "R7 R8 R10 flag", int'(uncorrectable), int'(m_unc));
      if (m_state == 2) begin
        chk(ram_addr == m_w[m_slot][24:16], "R4 addr", ram_addr, m_w[m_slot][24:16]);
        chk(ram_wdata == (ref_mem[m_w[m_slot][24:16]] ^ m_w[m_slot][7:0]), "R3 data",
            ram_wdata, ref_mem[m_w[m_slot][24:16]] ^ m_w[m_slot][7:0]);
      end
      if (ram_we) begin wr_q.push_back(int'(ram_addr)); writes++; end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 20000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic logic [31:0] wd(int idx, logic [7:0] m);
    return {16'(idx), 8'h00, m};
  endfunction

  task automatic restart();
    @(posedge clk); #1 sector_start = 1;
    @(posedge clk); #1 sector_start = 0;
  endtask

  task automatic run(logic [31:0] w0, w1, w2, w3, bit fail, output int lat);
    @(posedge clk); #1;
    res_words = {w3, w2, w1, w0}; dec_fail = fail; dec_end = 1;
    @(posedge clk); #1 dec_end = 0; dec_fail = 0;
    lat = 0;
    do begin @(negedge clk); lat++; end while (!fix_done && lat < 60);
  endtask

  initial begin
    int lat, w0;
    for (int i = 0; i < 512; i++) begin mem[i] = seed(i); ref_mem[i] = seed(i); end
    repeat (3) @(posedge clk);
    #1;
    chk(res_ready && !fix_done && !stat_clr && !uncorrectable && !ram_re && !ram_we,
        "R1 reset", int'(res_ready), 1);
    rst_n = 1;
    @(posedge clk);

    // three valid corrections and one empty slot
    wr_q.delete(); writes = 0;
    run(wd(5, 8'h81), NOERR, wd(511, 8'h3C), wd(0, 8'hFF), 0, lat);
    chk(lat == 8, "R9 latency", lat, 8);
    repeat (2) @(posedge clk);
    chk(mem[5] == (seed(5) ^ 8'h81), "R3 byte5", mem[5], seed(5) ^ 8'h81);
    chk(mem[511] == (seed(511) ^ 8'h3C), "R3 byte511", mem[511], seed(511) ^ 8'h3C);
    chk(mem[0] == (seed(0) ^ 8'hFF), "R3 byte0", mem[0], seed(0) ^ 8'hFF);
    chk(wr_q.size() == 3, "R5 write count", wr_q.size(), 3);
    if (wr_q.size() == 3) begin
      chk(wr_q[0] == 5 && wr_q[1] == 511 && wr_q[2] == 0, "R4 order", wr_q[0], 5);
    end
    chk(!uncorrectable, "R5 no flag", int'(uncorrectable), 0);

    // repeated end event for the same sector: nothing reapplied
    writes = 0;
    run(wd(5, 8'h81), NOERR, wd(511, 8'h3C), wd(0, 8'h01), 0, lat);
    chk(lat == 5, "R6 latency", lat, 5);
    chk(writes == 0, "R6 no writes", writes, 0);
    chk(mem[5] == (seed(5) ^ 8'h81), "R6 byte5 kept", mem[5], seed(5) ^ 8'h81);

    // new sector, out-of-range index in slot 1
    restart();
    writes = 0;
    run(wd(10, 8'h5A), wd(600, 8'h11), NOERR, NOERR, 0, lat);
    chk(lat == 6, "R8 latency", lat, 6);
    chk(writes == 1, "R8 one write", writes, 1);
    chk(uncorrectable, "R8 flag", int'(uncorrectable), 1);
    repeat (2) @(posedge clk);
    chk(mem[10] == (seed(10) ^ 8'h5A), "R3 byte10", mem[10], seed(10) ^ 8'h5A);
    chk(mem[600 - 512] == seed(88), "R8 alias untouched", mem[88], seed(88));

    // flag survives idle, cleared only by restart
    repeat (3) @(posedge clk);
    chk(uncorrectable, "R10 sticky", int'(uncorrectable), 1);
    restart();
    @(negedge clk);
    chk(!uncorrectable, "R10 cleared", int'(uncorrectable), 0);

    // decode failure wins over valid corrections
    writes = 0;
    run(wd(20, 8'h0F), wd(21, 8'hF0), NOERR, NOERR, 1, lat);
    chk(lat == 1, "R7 latency", lat, 1);
    chk(writes == 0, "R7 no writes", writes, 0);
    chk(uncorrectable, "R7 flag", int'(uncorrectable), 1);
    chk(mem[20] == seed(20), "R7 byte20", mem[20], seed(20));

    // busy-time strobe ignored, all-empty bundle
    restart();
    writes = 0;
    @(posedge clk); #1;
    res_words = {NOERR, NOERR, NOERR, wd(30, 8'h77)}; dec_end = 1;
    @(posedge clk); #1;
    res_words = {4{wd(40, 8'h22)}};
    @(posedge clk); #1 dec_end = 0;
    w0 = 0;
    do begin @(negedge clk); w0++; end while (!fix_done && w0 < 60);
    chk(w0 == 5, "R2 latency", w0, 5);
    @(negedge clk);
    chk(!fix_done, "R2 single done", int'(fix_done), 0);
    repeat (3) @(posedge clk);
    chk(writes == 1, "R2 ignored strobe", writes, 1);
    chk(mem[40] == seed(40), "R2 byte40", mem[40], seed(40));

    writes = 0;
    run(NOERR, NOERR, NOERR, NOERR, 0, lat);
    chk(lat == 5, "R5 empty latency", lat, 5);
    chk(writes == 0 && !uncorrectable, "R5 empty", writes, 0);

    repeat (4) @(posedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule